// File: doc/BRIEF.md
# Two-Level Token Column Readout

This block decides which pixel region in a column-organised array may place its hit word on the one data bus that all columns share. Every region raises a request when it holds data. A token chain inside each column finds the first requesting region of that column. A second token chain at the column ends then picks one column among those that have a candidate. The winning region's address and hit data are packed into one payload and protected with a single-error-correcting code before they go on the bus.

Chip control enables reading with a single level input. While that input is high, one word leaves the block per clock, together with a valid flag and a one-cycle acknowledge to the region that was read, so the region can withdraw its request. The order in which pending regions are served depends only on their positions, so the same hit pattern always yields the same word sequence.

Top module: `coltok_readout`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, bus_valid is 0, bus_word is all zero and region_ack is all zero.
- R2: When read_en is high at a clock edge and at least one eligible request is present, bus_valid is 1 after that edge and bus_word holds the winner's codeword, so one word moves per clock.
- R3: When read_en is low at a clock edge, that edge produces no valid word and no acknowledge; pending requests are kept and are served once read_en returns high.
- R4: Within one column, the region with the lowest row index is served first.
- R5: Across columns, the lowest column index holding an eligible request wins, so every pending region of a lower column is read before any region of a higher column. Region (c, r) sits at flat bit c*N_ROW + r of region_req, region_data (DATA_W bits per region) and region_ack.
- R6: region_ack is one-hot or zero; it is high for exactly one cycle, on the served region only, in the same cycle as its word, and only for a region that was requesting at the edge that served it.
- R7: A region acknowledged in a cycle is not eligible at the next edge, even if its request is still high, so no region is read twice in a row.
- R8: The payload is, from bit 0 upward: DATA_W data bits, then an N_ROW-1 bit thermometer code of the row (row r sets bits 0..r-1 of that field), then an N_COL-1 bit thermometer code of the column, then zero padding up to a multiple of 4 bits.
- R9: Payload nibble j is encoded into bus_word bits 7j+6..7j as {d3, d2, d1, p4, d0, p2, p1}, where p1 = d0^d1^d3, p2 = d0^d2^d3 and p4 = d1^d2^d3.
- R10: In any cycle without a valid word, bus_word is the all-zero codeword.
- R11: Presenting the same set of requests twice gives the same sequence of served regions.
- R12: A request that arrives while other words are being read takes its priority place at the next edge: if it ranks above the remaining ones it is served before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| read_en | input | 1 | Read enable from chip control |
| region_req | input | N_COL*N_ROW | Per-region readout request, flat index c*N_ROW + r |
| region_data | input | N_COL*N_ROW*DATA_W | Per-region hit data, DATA_W bits each |
| bus_word | output | 7*ceil((N_COL+N_ROW+DATA_W-2)/4) | Encoded word on the shared bus |
| bus_valid | output | 1 | bus_word carries a served region |
| region_ack | output | N_COL*N_ROW | One-cycle acknowledge to the served region |

## Verification
Arbitration is combinational and the bus word, valid flag and acknowledge are registered, so every result appears one clock edge after the request pattern and read enable that produced it. The bench drives inputs on the falling edge, computes the word due after the next rising edge from its own priority scan and code arithmetic, queues it, and a monitor compares it one nanosecond after that rising edge. Regions are modelled as clearing their requests either during the acknowledge cycle or one cycle late, the second case exercising the masking of the just-served region.

// File: rtl/coltok_pkg.sv
package coltok_pkg;

  // Width of the bus word: payload padded to whole nibbles, 7 bits per nibble.
  function automatic int code_width(input int n_col, input int n_row, input int data_w);
    int raw_w;
    raw_w = (n_col - 1) + (n_row - 1) + data_w;
    return ((raw_w + 3) / 4) * 7;
  endfunction

  // Single-error-correcting code for one nibble, laid out as {d3,d2,d1,p4,d0,p2,p1}.
  function automatic logic [6:0] ham74_encode(input logic [3:0] d);
    logic p1, p2, p4;
    p1 = d[0] ^ d[1] ^ d[3];
    p2 = d[0] ^ d[2] ^ d[3];
    p4 = d[1] ^ d[2] ^ d[3];
    return {d[3], d[2], d[1], p4, d[0], p2, p1};
  endfunction

endpackage

// File: rtl/coltok_token_pick.sv
// Token chain: the token enters at index 0 and is absorbed by the first
// requester, so the lowest index wins. Carries the winner's payload out.
module coltok_token_pick #(
  parameter int N = 8,
  parameter int P = 8
) (
  input  logic [N-1:0]         req,
  input  logic [N*P-1:0]       pay_in,
  output logic                 any,
  output logic [$clog2(N)-1:0] idx,
  output logic [P-1:0]         pay_out
);
  localparam int IW = $clog2(N);

  logic [N:0]   tok;
  logic [N-1:0] grant;

  assign tok[0] = 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign grant[i]  = tok[i] & req[i];
    assign tok[i+1]  = tok[i] & ~req[i];
  end

  assign any = ~tok[N];

  always_comb begin
    idx     = '0;
    pay_out = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) begin
        idx     = idx | IW'(i);
        pay_out = pay_out | pay_in[i*P +: P];
      end
    end
  end

endmodule

// File: rtl/coltok_word_enc.sv
// Packs column/row thermometer codes and data, then encodes each nibble.
module coltok_word_enc #(
  parameter int N_COL  = 4,
  parameter int N_ROW  = 8,
  parameter int DATA_W = 8
) (
  input  logic [$clog2(N_COL)-1:0] col,
  input  logic [$clog2(N_ROW)-1:0] row,
  input  logic [DATA_W-1:0]        data,
  output logic [coltok_pkg::code_width(N_COL, N_ROW, DATA_W)-1:0] word
);
  localparam int COL_TW = N_COL - 1;
  localparam int ROW_TW = N_ROW - 1;
  localparam int RAW_W  = COL_TW + ROW_TW + DATA_W;
  localparam int NIB    = (RAW_W + 3) / 4;
  localparam int PAY_W  = NIB * 4;

  function automatic logic [ROW_TW-1:0] row_thermo(input int n);
    logic [ROW_TW-1:0] t;
    for (int k = 0; k < ROW_TW; k++) t[k] = (k < n);
    return t;
  endfunction

  function automatic logic [COL_TW-1:0] col_thermo(input int n);
    logic [COL_TW-1:0] t;
    for (int k = 0; k < COL_TW; k++) t[k] = (k < n);
    return t;
  endfunction

  logic [PAY_W-1:0] payload;

  assign payload = PAY_W'({col_thermo(int'(col)), row_thermo(int'(row)), data});

  for (genvar j = 0; j < NIB; j++) begin : g_nib
    assign word[7*j +: 7] = coltok_pkg::ham74_encode(payload[4*j +: 4]);
  end

endmodule

// File: rtl/coltok_readout.sv
module coltok_readout #(
  parameter int N_COL  = 4,
  parameter int N_ROW  = 8,
  parameter int DATA_W = 8
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 read_en,
  input  logic [N_COL*N_ROW-1:0]               region_req,
  input  logic [N_COL*N_ROW*DATA_W-1:0]        region_data,
  output logic [coltok_pkg::code_width(N_COL, N_ROW, DATA_W)-1:0] bus_word,
  output logic                                 bus_valid,
  output logic [N_COL*N_ROW-1:0]               region_ack
);
  localparam int NREG   = N_COL * N_ROW;
  localparam int ROW_IW = $clog2(N_ROW);
  localparam int COL_IW = $clog2(N_COL);
  localparam int CP     = ROW_IW + DATA_W;
  localparam int CODE_W = coltok_pkg::code_width(N_COL, N_ROW, DATA_W);

  // Requests minus the region served last cycle (it may still be clearing).
  logic [NREG-1:0]       eligible;
  logic [N_COL-1:0]      col_any;
  logic [N_COL*CP-1:0]   col_pay;
  logic                  win_any;
  logic [COL_IW-1:0]     win_col;
  logic [CP-1:0]         win_pay;
  logic [ROW_IW-1:0]     win_row;
  logic [DATA_W-1:0]     win_data;
  logic [CODE_W-1:0]     word_d;
  logic                  read_fire;
  logic [NREG-1:0]       ack_d;

  assign eligible = region_req & ~region_ack;

  // Column level: one token chain per column.
  for (genvar c = 0; c < N_COL; c++) begin : g_col
    coltok_token_pick #(.N(N_ROW), .P(DATA_W)) u_chain (
      .req     (eligible[c*N_ROW +: N_ROW]),
      .pay_in  (region_data[c*N_ROW*DATA_W +: N_ROW*DATA_W]),
      .any     (col_any[c]),
      .idx     (col_pay[c*CP+DATA_W +: ROW_IW]),
      .pay_out (col_pay[c*CP +: DATA_W])
    );
  end

  // Periphery level: token chain across the column ends.
  coltok_token_pick #(.N(N_COL), .P(CP)) u_periph (
    .req     (col_any),
    .pay_in  (col_pay),
    .any     (win_any),
    .idx     (win_col),
    .pay_out (win_pay)
  );

  assign win_row  = win_pay[DATA_W +: ROW_IW];
  assign win_data = win_pay[DATA_W-1:0];

  coltok_word_enc #(.N_COL(N_COL), .N_ROW(N_ROW), .DATA_W(DATA_W)) u_enc (
    .col  (win_col),
    .row  (win_row),
    .data (win_data),
    .word (word_d)
  );

  assign read_fire = read_en & win_any;

  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      ack_d[i] = read_fire && (i == (int'(win_col) * N_ROW + int'(win_row)));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_word   <= '0;
      bus_valid  <= 1'b0;
      region_ack <= '0;
    end else begin
      bus_word   <= read_fire ? word_d : '0;
      bus_valid  <= read_fire;
      region_ack <= ack_d;
    end
  end

endmodule

// File: rtl/coltok_readout_chk.sv
module coltok_readout_chk #(
  parameter int NREG   = 32,
  parameter int CODE_W = 35
) (
  input logic              clk,
  input logic              rst,
  input logic              read_en,
  input logic [NREG-1:0]   region_req,
  input logic [NREG-1:0]   region_ack,
  input logic              bus_valid,
  input logic [CODE_W-1:0] bus_word,
  input logic              win_any
);

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_ack)); // R6

  AST_VALID_WITH_ACK: assert property (@(posedge clk) disable iff (rst)
    bus_valid == (region_ack != '0)); // R6

  AST_ACK_WAS_REQUESTED: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((region_ack & ~$past(region_req)) == '0)); // R6

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |-> (bus_word == '0)); // R10

  AST_DISABLED_NO_READ: assert property (@(posedge clk) disable iff (rst)
    !read_en |=> !bus_valid); // R3

  AST_PENDING_SERVED: assert property (@(posedge clk) disable iff (rst)
    (read_en && win_any) |=> bus_valid); // R2

  AST_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (region_ack != '0) |=> ((region_ack & $past(region_ack)) == '0)); // R7

  AST_NIB0_PARITY: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> (bus_word[0] == (bus_word[2] ^ bus_word[4] ^ bus_word[6]))); // R9

endmodule

bind coltok_readout coltok_readout_chk #(.NREG(NREG), .CODE_W(CODE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .read_en    (read_en),
  .region_req (region_req),
  .region_ack (region_ack),
  .bus_valid  (bus_valid),
  .bus_word   (bus_word),
  .win_any    (win_any)
);

// File: tb/coltok_readout_tb.sv
module coltok_readout_tb;
  localparam int N_COL  = 4;
  localparam int N_ROW  = 8;
  localparam int DATA_W = 8;
  localparam int NREG   = N_COL * N_ROW;
  localparam int NIB    = (N_COL + N_ROW + DATA_W - 2 + 3) / 4;
  localparam int PAY_W  = NIB * 4;
  localparam int CODE_W = NIB * 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                     rst;
  logic                     read_en;
  logic [NREG-1:0]          req;
  logic [NREG*DATA_W-1:0]   data;
  logic [CODE_W-1:0]        bus_word;
  logic                     bus_valid;
  logic [NREG-1:0]          region_ack;

  coltok_readout #(.N_COL(N_COL), .N_ROW(N_ROW), .DATA_W(DATA_W)) u_dut (
    .clk (clk), .rst (rst), .read_en (read_en),
    .region_req (req), .region_data (data),
    .bus_word (bus_word), .bus_valid (bus_valid), .region_ack (region_ack)
  );

  typedef struct {
    logic [CODE_W-1:0] w;
    logic              v;
    logic [NREG-1:0]   a;
    string             tag;
  } exp_t;

  exp_t            sb[$];
  logic [NREG-1:0] seq_a[$];
  logic [NREG-1:0] seq_b[$];
  int              checks = 0;
  int              fails  = 0;
  int              rec    = 0;
  bit              late   = 1'b0;
  string           cur_tag = "R2";
  logic [NREG-1:0] m_req, ack_last, ack_older;
  logic [DATA_W-1:0] rdata [NREG];

  // Nibble code built from bit positions 1..7: data at 3,5,6,7, parity at 1,2,4.
  function automatic logic [6:0] ham7(input logic [3:0] d);
    logic [7:1] pos;
    pos = '0;
    pos[3] = d[0]; pos[5] = d[1]; pos[6] = d[2]; pos[7] = d[3];
    for (int p = 1; p <= 4; p = p * 2) begin
      logic x;
      x = 1'b0;
      for (int k = 1; k <= 7; k++)
        if (k != p && (k & p) != 0) x = x ^ pos[k];
      pos[p] = x;
    end
    return pos[7:1];
  endfunction

  function automatic logic [CODE_W-1:0] exp_word(input int idx);
    logic [PAY_W-1:0]  p;
    logic [CODE_W-1:0] w;
    int c, r;
    c = idx / N_ROW;
    r = idx % N_ROW;
    p = '0;
    p[DATA_W-1:0] = rdata[idx];
    p = p | (PAY_W'((1 << r) - 1) << DATA_W);
    p = p | (PAY_W'((1 << c) - 1) << (DATA_W + N_ROW - 1));
    for (int j = 0; j < NIB; j++) w[7*j +: 7] = ham7(p[4*j +: 4]);
    return w;
  endfunction

  function automatic logic [NREG-1:0] rb(input int c, input int r);
    logic [NREG-1:0] m;
    m = '0;
    m[c*N_ROW + r] = 1'b1;
    return m;
  endfunction

  // Driver: one falling edge per call; pushes the word due after the next rising edge.
  task automatic tick(input logic [NREG-1:0] add, input bit rd);
    exp_t e;
    logic [NREG-1:0] eff;
    @(negedge clk);
    m_req = m_req & ~(late ? ack_older : ack_last);
    m_req = m_req | add;
    req = m_req;
    read_en = rd;
    for (int i = 0; i < NREG; i++) data[i*DATA_W +: DATA_W] = rdata[i];
    eff = m_req & ~ack_last;
    e.v = 1'b0; e.w = '0; e.a = '0; e.tag = cur_tag;
    if (rd) begin
      for (int i = 0; i < NREG; i++) begin
        if (eff[i] && !e.v) begin
          e.v = 1'b1; e.a[i] = 1'b1; e.w = exp_word(i);
        end
      end
    end
    sb.push_back(e);
    ack_older = ack_last;
    ack_last  = e.a;
  endtask

  task automatic drain();
    for (int k = 0; k < 200 && m_req != '0; k++) tick('0, 1'b1);
    tick('0, 1'b1);
    tick('0, 1'b1);
  endtask

  // Monitor: compares one nanosecond after each rising edge.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (!rst && sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (bus_word !== e.w || bus_valid !== e.v || region_ack !== e.a) begin
          fails++;
          $display("FAIL %s: word=%h exp=%h valid=%b exp=%b ack=%h exp=%h",
                   e.tag, bus_word, e.w, bus_valid, e.v, region_ack, e.a);
        end
        if (bus_valid === 1'b1 && rec == 1) seq_a.push_back(region_ack);
        if (bus_valid === 1'b1 && rec == 2) seq_b.push_back(region_ack);
      end
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
  end

  initial begin
    logic [NREG-1:0] pat;
    rst = 1'b1; read_en = 1'b0; req = '0; data = '0;
    m_req = '0; ack_last = '0; ack_older = '0;
    for (int i = 0; i < NREG; i++) rdata[i] = DATA_W'(i * 29 + 7);
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (bus_word !== '0 || bus_valid !== 1'b0 || region_ack !== '0) begin
      fails++;
      $display("FAIL R1: word=%h valid=%b ack=%h exp=0/0/0", bus_word, bus_valid, region_ack);
    end
    rst = 1'b0;

    // R1 first cycle after reset, and R10 idle bus with read enabled
    cur_tag = "R1 R10";
    tick('0, 1'b1);
    tick('0, 1'b1);

    // R2 R8: single region, address codes
    cur_tag = "R2 R8";
    tick(rb(2, 5), 1'b1);
    drain();
    tick(rb(3, 7), 1'b1);
    drain();
    tick(rb(0, 0), 1'b1);
    drain();

    // R4: several rows of one column
    cur_tag = "R4";
    tick(rb(1, 6) | rb(1, 3) | rb(1, 0) | rb(1, 7), 1'b1);
    drain();

    // R5: spread across columns
    cur_tag = "R5";
    tick(rb(3, 0) | rb(1, 7) | rb(0, 4) | rb(2, 2) | rb(0, 6), 1'b1);
    drain();

    // R3: requests held while reading is disabled, then served
    cur_tag = "R3";
    tick(rb(2, 1) | rb(0, 3), 1'b0);
    repeat (3) tick('0, 1'b0);
    drain();

    // R7: regions that withdraw one cycle late
    cur_tag = "R7";
    late = 1'b1;
    tick(rb(1, 2), 1'b1);
    drain();
    tick(rb(2, 4) | rb(2, 5), 1'b1);
    drain();
    late = 1'b0;

    // R12: higher-priority request arriving mid-readout
    cur_tag = "R12";
    tick(rb(3, 7) | rb(3, 0) | rb(2, 6), 1'b1);
    tick(rb(0, 1), 1'b1);
    drain();

    // R9: data values with many set bits
    cur_tag = "R9";
    rdata[9]  = 8'hFF;
    rdata[20] = 8'hA5;
    rdata[31] = 8'h5A;
    tick(rb(1, 1) | rb(2, 4) | rb(3, 7), 1'b1);
    drain();

    // R11: same pattern twice, same sequence
    cur_tag = "R11";
    pat = rb(3, 3) | rb(0, 5) | rb(2, 0) | rb(0, 2) | rb(1, 6);
    rec = 1;
    tick(pat, 1'b1);
    drain();
    rec = 2;
    tick(pat, 1'b1);
    drain();
    rec = 0;
    checks++;
    if (seq_a.size() != 5 || seq_a != seq_b) begin
      fails++;
      $display("FAIL R11: first run %0d words, second run %0d words, expected 5 identical",
               seq_a.size(), seq_b.size());
    end

    @(negedge clk);
    @(negedge clk);
    summary();
  end

endmodule